// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Shared Parallel Port

This block is a parameterised register (eight bits by default) with four synchronous behaviours: keep its contents, shift toward the high end, shift toward the low end, or load a whole word in parallel. A two-bit mode select picks the behaviour on each rising clock edge. An active-low synchronous reset clears the register and takes priority over every other input.

Parallel data comes in and goes out through one shared bidirectional port. The port is modelled as an input vector, an output vector and a per-bit output-enable vector. The port drives the register contents only when both active-low enables are low. The parallel-load mode releases the port in every case, so that an external source can drive the word that is captured. Each end of the register has its own serial input. Two serial taps show the end bits at all times, whatever the port direction.

Bit 0 is the low end and bit WIDTH-1 is the high end. Shifting toward the high end is used to cascade words in one direction, and shifting toward the low end cascades them in the other.

Top module: `usr_shift_reg`

## Requirements
- R1: With `mode_sel` = 2'b00 and reset inactive, the register keeps its value across the clock edge, whatever the serial inputs are.
- R2: With `mode_sel` = 2'b01, bit i+1 takes the old bit i on the clock edge, and bit 0 takes `ser_in_lo`.
- R3: With `mode_sel` = 2'b10, bit i takes the old bit i+1 on the clock edge, and bit WIDTH-1 takes `ser_in_hi`.
- R4: With `mode_sel` = 2'b11, the register takes `port_in` on the clock edge.
- R5: With `rst_n` low at a rising edge, every register bit becomes 0, whatever the mode and the serial inputs are.
- R6: `port_oe` is all ones only when `oe_n_a` and `oe_n_b` are both low and `mode_sel` is not 2'b11, and all zeros otherwise. While it is all ones, `port_out` equals the register.
- R7: With `mode_sel` = 2'b11, `port_oe` is all zeros even when both enables are low.
- R8: The state of the enables has no effect on how the register holds, shifts, loads or clears.
- R9: `ser_out_lo` always equals register bit 0 and `ser_out_hi` always equals bit WIDTH-1. Both stay driven while the port is disabled.
- R10: Reset is seen only at a rising edge. Lowering `rst_n` between edges changes neither the register nor the serial outputs until the next edge.
- R11: After a reset edge, an enabled port in a non-load mode drives all zeros. In load mode the port stays released during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| mode_sel | input | 2 | 00 keep, 01 shift toward high end, 10 shift toward low end, 11 parallel load |
| oe_n_a | input | 1 | First port enable, active low |
| oe_n_b | input | 1 | Second port enable, active low |
| ser_in_lo | input | 1 | Serial input entering bit 0 |
| ser_in_hi | input | 1 | Serial input entering bit WIDTH-1 |
| port_in | input | WIDTH | Value seen on the shared port pins |
| port_out | output | WIDTH | Value the register presents to the shared port |
| port_oe | output | WIDTH | Per-pin drive enable of the shared port |
| ser_out_lo | output | 1 | Always-driven copy of bit 0 |
| ser_out_hi | output | 1 | Always-driven copy of bit WIDTH-1 |

## Verification
Shifting is tried with alternating serial bits and with runs of equal bits in both directions. A wrong shift direction or a serial input entering at the wrong end then shows up as a different word. Parallel loads use complementary words such as 0xA5 and 0x5A, which tell a correct capture apart from a capture of the register's own output. Every mode is repeated with the port disabled through each enable alone and through both. This separates a correct direction decode from one that lets the enables gate the register update. Reset is applied together with shifting inputs, in load mode, and between clock edges. These cases show that the clear is synchronous and that it takes priority.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP    = 2'b00,
    MODE_ASCEND  = 2'b01,
    MODE_DESCEND = 2'b10,
    MODE_LOAD    = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  output mode_e      mode,
  output logic       is_load,
  output logic       is_shift
);
  always_comb begin
    mode     = mode_e'(mode_sel);
    is_load  = (mode == MODE_LOAD);
    is_shift = (mode == MODE_ASCEND) || (mode == MODE_DESCEND);
  end
endmodule

// File: rtl/usr_core.sv
module usr_core
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             ser_lo,
  input  logic             ser_hi,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int MSB = WIDTH - 1;

  // Move every bit one place toward the high end; fill bit 0.
  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v, input logic fill);
    return {v[MSB-1:0], fill};
  endfunction

  // Move every bit one place toward the low end; fill the top bit.
  function automatic logic [WIDTH-1:0] step_down(input logic [WIDTH-1:0] v, input logic fill);
    return {fill, v[MSB:1]};
  endfunction

  logic [WIDTH-1:0] q_next;

  always_comb begin
    unique case (mode)
      MODE_ASCEND:  q_next = step_up(q, ser_lo);
      MODE_DESCEND: q_next = step_down(q, ser_hi);
      MODE_LOAD:    q_next = par_in;
      default:      q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_KEEP) |=> (q == $past(q)));

  p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ASCEND) |=> (q[0] == $past(ser_lo)) && (q[MSB:1] == $past(q[MSB-1:0])));

  p_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DESCEND) |=> (q[MSB] == $past(ser_hi)) && (q[MSB-1:0] == $past(q[MSB:1])));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (q == $past(par_in)));

  // R5: remember whether the last edge saw reset, then check the result one edge later.
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;

  always @(posedge clk) begin
    if (rst_seen_q === 1'b1) begin
      p_sync_clear_r5: assert (q == '0) else $error("register not cleared after reset edge");
    end
  end
endmodule

// File: rtl/usr_port_ctl.sv
module usr_port_ctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic             oe_n_a,
  input  logic             oe_n_b,
  input  logic             is_load,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe
);
  logic drive_en;

  // The port drives only if both enables are low, and never in load mode.
  assign drive_en = !oe_n_a && !oe_n_b && !is_load;
  assign port_out = q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign port_oe[i] = drive_en;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_n_a,
  input  logic             oe_n_b,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int MSB = WIDTH - 1;

  mode_e            mode;
  logic             is_load;
  logic             is_shift;
  logic [WIDTH-1:0] q;

  usr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .mode     (mode),
    .is_load  (is_load),
    .is_shift (is_shift)
  );

  usr_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .ser_lo (ser_in_lo),
    .ser_hi (ser_in_hi),
    .par_in (port_in),
    .q      (q)
  );

  usr_port_ctl #(.WIDTH(WIDTH)) u_port (
    .q        (q),
    .oe_n_a   (oe_n_a),
    .oe_n_b   (oe_n_b),
    .is_load  (is_load),
    .port_out (port_out),
    .port_oe  (port_oe)
  );

  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];

  p_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_a && !oe_n_b && !is_load) |-> (port_oe == '1) && (port_out[0] == ser_out_lo));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n_a || oe_n_b) |-> (port_oe == '0));

  p_load_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (port_oe == '0));

  p_tap_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> (ser_out_lo == $past(ser_in_lo)));

  p_tap_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> (ser_out_hi == $past(ser_in_hi)));

  p_shift_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |-> (mode_sel[0] != mode_sel[1]));
endmodule

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_sel;
  logic         oe_n_a, oe_n_b, ser_in_lo, ser_in_hi;
  logic [W-1:0] port_in, port_out, port_oe;
  logic         ser_out_lo, ser_out_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  usr_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .oe_n_a(oe_n_a), .oe_n_b(oe_n_b),
    .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reference update, written bit by bit from the requirements.
  task automatic edge_step();
    logic [W-1:0] nx;
    nx = model;
    if (!rst_n) nx = '0;
    else if (mode_sel == 2'b01) begin
      for (int i = W - 1; i > 0; i--) nx[i] = model[i-1];
      nx[0] = ser_in_lo;
    end else if (mode_sel == 2'b10) begin
      for (int i = 0; i < W - 1; i++) nx[i] = model[i+1];
      nx[W-1] = ser_in_hi;
    end else if (mode_sel == 2'b11) nx = port_in;
    @(posedge clk);
    model = nx;
    @(negedge clk);
  endtask

  // Reads the register through the port: keep mode, both enables low.
  task automatic peek(input string req);
    logic [1:0] m; logic a, b;
    m = mode_sel; a = oe_n_a; b = oe_n_b;
    mode_sel = 2'b00; oe_n_a = 0; oe_n_b = 0; #1;
    check(req, port_oe, {W{1'b1}});
    check(req, port_out, model);
    check(req, {ser_out_hi, ser_out_lo}, {model[W-1], model[0]});
    mode_sel = m; oe_n_a = a; oe_n_b = b; #1;
  endtask

  task automatic t_reset();
    rst_n = 0; mode_sel = 2'b01; ser_in_lo = 1; ser_in_hi = 1; oe_n_a = 0; oe_n_b = 0;
    edge_step(); edge_step();
    check("R5 clear", port_out, 0);
    check("R11 enabled port drives zeros in reset", port_oe, {W{1'b1}});
    check("R9 taps after reset", {ser_out_hi, ser_out_lo}, 0);
    mode_sel = 2'b11; #1;
    check("R11 load mode keeps port released in reset", port_oe, 0);
    edge_step();
    check("R5 reset overrides load", ser_out_lo, 0);
    rst_n = 1;
  endtask

  task automatic t_load();
    oe_n_a = 0; oe_n_b = 0; mode_sel = 2'b11; port_in = 8'hA5; #1;
    check("R7 load forces hi-z", port_oe, 0);
    edge_step(); peek("R4 load A5");
    mode_sel = 2'b11; port_in = 8'h5A; edge_step(); peek("R4 load 5A");
  endtask

  task automatic t_keep();
    mode_sel = 2'b00;
    for (int k = 0; k < 4; k++) begin
      ser_in_lo = k[0]; ser_in_hi = ~k[0]; port_in = 8'hFF; edge_step();
    end
    peek("R1 keep");
  endtask

  task automatic t_ascend();
    logic [7:0] pat = 8'b1101_0010;
    mode_sel = 2'b01;
    for (int k = 0; k < 8; k++) begin
      ser_in_lo = pat[k]; ser_in_hi = ~pat[k]; edge_step();
      check("R2 shift up", {ser_out_hi, ser_out_lo}, {model[W-1], model[0]});
    end
    peek("R2 shift up word");
    for (int k = 0; k < 3; k++) begin ser_in_lo = 1; edge_step(); end
    peek("R2 run of ones");
  endtask

  task automatic t_descend();
    logic [7:0] pat = 8'b0110_1011;
    mode_sel = 2'b10;
    for (int k = 0; k < 8; k++) begin
      ser_in_hi = pat[k]; ser_in_lo = ~pat[k]; edge_step();
      check("R3 shift down", {ser_out_hi, ser_out_lo}, {model[W-1], model[0]});
    end
    peek("R3 shift down word");
  endtask

  task automatic t_disabled();
    for (int e = 1; e < 4; e++) begin
      oe_n_a = e[0]; oe_n_b = e[1]; mode_sel = 2'b00; #1;
      check("R6 disabled port released", port_oe, 0);
      mode_sel = 2'b01; ser_in_lo = e[0]; edge_step();
      check("R9 taps while disabled", {ser_out_hi, ser_out_lo}, {model[W-1], model[0]});
      mode_sel = 2'b10; ser_in_hi = e[1]; edge_step();
      mode_sel = 2'b11; port_in = 8'h3C ^ W'(e); edge_step();
      check("R8 load while disabled", ser_out_hi, model[W-1]);
      peek("R8 disabled enables do not gate update");
    end
    oe_n_a = 1; oe_n_b = 1; rst_n = 0; mode_sel = 2'b01; edge_step(); rst_n = 1;
    peek("R8 clear while disabled");
  endtask

  task automatic t_mid_reset();
    mode_sel = 2'b11; port_in = 8'h81; oe_n_a = 0; oe_n_b = 0; edge_step();
    mode_sel = 2'b00; #1;
    rst_n = 0; #2;
    check("R10 no async clear", {ser_out_hi, ser_out_lo}, 2'b11);
    check("R10 port unchanged between edges", port_out, 8'h81);
    edge_step(); rst_n = 1;
    check("R10 cleared at edge", port_out, 0);
  endtask

  initial begin
    rst_n = 0; mode_sel = 0; oe_n_a = 1; oe_n_b = 1; ser_in_lo = 0; ser_in_hi = 0;
    port_in = 0; model = 0;
    @(negedge clk);
    t_reset(); t_load(); t_keep(); t_ascend(); t_descend(); t_disabled(); t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule